// File: doc/BRIEF.md
# Packed Palette RAM with Color Expansion

This block holds a 256-entry color lookup table for an indexed-color display pipeline. Software fills it through a 128-word window in the register space; each 32-bit word carries two 16-bit table entries. Each entry holds three 5-bit color fields and one spare bit that has no effect on the color.

The pixel side presents an 8-bit color index and receives a 24-bit color one clock later. The block widens each 5-bit field to 8 bits by shifting it left three places, so the low three bits of every channel are zero. Bus reads return the packed word exactly as it was written, spare bits included.

Reset is asynchronous and active-low. Its release is expected to be synchronized to `clk` upstream.

Top module: `palx_ram_top`

## Requirements
- R1: After reset, `pix_vld` is 0, `pix_rgb` is 0, `bus_rdata` is 0, and every palette word reads back as 0.
- R2: The window covers byte offsets 0x200 to 0x3FF. Word n lives at offset 0x200 + 4n. A write outside the window changes no word, and a read outside the window returns 0.
- R3: `bus_rdata` holds the raw 32-bit word last written to the addressed location, all bits included. It is valid in the cycle after `bus_rd` and holds its value while `bus_rd` is low.
- R4: Entry 2n comes from bits 15:0 of word n, and entry 2n+1 comes from bits 31:16 of word n. The low bit of `pix_idx` selects the half.
- R5: Within a 16-bit entry, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. `pix_rgb` is packed with red in bits 23:16, green in 15:8 and blue in 7:0.
- R6: Each channel equals its 5-bit field shifted left by 3, so the low three bits are zero. Bit 15 of an entry has no effect on `pix_rgb`.
- R7: `pix_vld` is high in exactly the cycle after a cycle with `pix_req` high. `pix_rgb` keeps its value in cycles that follow a cycle with no request. One lookup per cycle is accepted.
- R8: If a bus write and a lookup address the same word in the same cycle, the lookup returns the color from before the write. The next lookup returns the new color.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the bus access |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data (two packed entries) |
| bus_rd | input | 1 | Bus read strobe |
| bus_rdata | output | 32 | Registered bus read data |
| pix_req | input | 1 | Lookup request |
| pix_idx | input | 8 | Palette index to look up |
| pix_rgb | output | 24 | Expanded color {red, green, blue} |
| pix_vld | output | 1 | Lookup result valid |

## Verification
A corrupted stored word shows up twice at the ports. It appears on the next bus read of that word, one cycle after `bus_rd`, and on the next lookup of either of its two entries, one cycle after `pix_req`. Those two views must agree with each other. A wrong half-select or field slice lets a value written into one color field appear in another channel or entry, so the bench writes words that light a single field. A wrong window decode aliases an out-of-window write onto word 0 or word 127, which the next read of those words exposes. A write-first collision path shows up as the new color in the cycle after a same-cycle write and lookup.

// File: rtl/palx_pkg.sv
package palx_pkg;
  localparam int COMP_W  = 5;
  localparam int CH_W    = 8;
  localparam int ENTRY_W = 16;
  localparam int WORD_W  = 2 * ENTRY_W;
  localparam int RGB_W   = 3 * CH_W;
  localparam int SHIFT   = CH_W - COMP_W;

  // widen one 5:5:5 entry to {red, green, blue}, 8 bits each
  function automatic logic [RGB_W-1:0] widen(input logic [ENTRY_W-1:0] e);
    logic [COMP_W-1:0] r, g, b;
    r = e[COMP_W-1:0];
    g = e[2*COMP_W-1:COMP_W];
    b = e[3*COMP_W-1:2*COMP_W];
    return {r, SHIFT'(0), g, SHIFT'(0), b, SHIFT'(0)};
  endfunction
endpackage

// File: rtl/palx_win_decode.sv
module palx_win_decode #(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int WORDS  = 128,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [WIDX_W-1:0] widx
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + 4 * WORDS);

  logic [ADDR_W:0] off;
  logic            unused_off;

  always_comb begin
    off  = {1'b0, addr} - LO;
    hit  = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    widx = off[WIDX_W+1:2];
  end

  assign unused_off = ^{off[ADDR_W:WIDX_W+2], off[1:0]};
endmodule

// File: rtl/palx_word_store.sv
module palx_word_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WIDX_W-1:0] widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WIDX_W-1:0] ridx_a,
  output logic [WORD_W-1:0] rdata_a,
  input  logic [WIDX_W-1:0] ridx_b,
  output logic [WORD_W-1:0] rdata_b
);
  logic [WORD_W-1:0] words [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else if (we) begin
      words[widx] <= wdata;
    end
  end

  // both read ports see pre-write contents in a write cycle
  always_comb begin
    rdata_a = words[ridx_a];
    rdata_b = words[ridx_b];
  end

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (words[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/palx_color_lookup.sv
module palx_color_lookup
  import palx_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              half_hi,
  input  logic [WORD_W-1:0] word_in,
  output logic [RGB_W-1:0]  rgb_q,
  output logic              vld_q
);
  logic [ENTRY_W-1:0] entry;
  logic [RGB_W-1:0]   rgb_d;
  logic               vld_d;

  always_comb begin
    entry = half_hi ? word_in[WORD_W-1:ENTRY_W] : word_in[ENTRY_W-1:0];
    rgb_d = req ? widen(entry) : rgb_q;
    vld_d = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q <= '0;
      vld_q <= 1'b0;
    end else begin
      rgb_q <= rgb_d;
      vld_q <= vld_d;
    end
  end

  p_vld_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> vld_q);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(rgb_q) && !vld_q));
  p_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (rgb_q[SHIFT-1:0] == '0 && rgb_q[CH_W+SHIFT-1:CH_W] == '0
               && rgb_q[2*CH_W+SHIFT-1:2*CH_W] == '0));
endmodule

// File: rtl/palx_ram_top.sv
module palx_ram_top
  import palx_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int WORDS  = 128,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int PIX_W  = WIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              pix_req,
  input  logic [PIX_W-1:0]  pix_idx,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic              pix_vld
);
  logic              win_hit;
  logic [WIDX_W-1:0] win_idx;
  logic [WORD_W-1:0] word_a, word_b;
  logic [WORD_W-1:0] rdata_d, rdata_q;
  logic              wr_en;

  palx_win_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) u_dec (
    .addr (bus_addr),
    .hit  (win_hit),
    .widx (win_idx)
  );

  assign wr_en = bus_wr & win_hit;

  palx_word_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .widx    (win_idx),
    .wdata   (bus_wdata),
    .ridx_a  (win_idx),
    .rdata_a (word_a),
    .ridx_b  (pix_idx[PIX_W-1:1]),
    .rdata_b (word_b)
  );

  palx_color_lookup #(.PIX_W(PIX_W)) u_look (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (pix_req),
    .half_hi (pix_idx[0]),
    .word_in (word_b),
    .rgb_q   (pix_rgb),
    .vld_q   (pix_vld)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = win_hit ? word_a : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  p_outside_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !win_hit) |=> (bus_rdata == '0));
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/palx_ram_top_tb_top.sv
`timescale 1ns/1ps
module palx_ram_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        pix_req = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;
  logic        pix_vld;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [31:0] model [128];
  logic [23:0] expq [$];

  always #5 clk = ~clk;

  palx_ram_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pix_req(pix_req), .pix_idx(pix_idx), .pix_rgb(pix_rgb), .pix_vld(pix_vld)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // color expected from R4/R5/R6
  function automatic logic [23:0] color_of(input logic [7:0] idx);
    logic [15:0] e;
    e = idx[0] ? model[idx[7:1]][31:16] : model[idx[7:1]][15:0];
    return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
  endfunction

  function automatic bit in_win(input logic [11:0] a);
    return (a >= 12'h200) && (a <= 12'h3FF);
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (in_win(a)) model[(a - 12'h200) >> 2] = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic lookup(input logic [7:0] idx);
    pix_idx = idx; pix_req = 1'b1;
    expq.push_back(color_of(idx));
    @(negedge clk);
    pix_req = 1'b0;
  endtask

  // monitor: scoreboard for lookups (R4 R5 R6 R7)
  always @(negedge clk) begin
    if (rst_n && pix_vld) begin
      if (expq.size() == 0) check("R7 unexpected valid", 32'(pix_rgb), 32'hdead);
      else check("R5 lookup color", 32'(pix_rgb), 32'(expq.pop_front()));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R7 act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pix_vld", 32'(pix_vld), 0);
    check("R1 pix_rgb", 32'(pix_rgb), 0);
    check("R1 bus_rdata", bus_rdata, 0);
    bus_read("R1 word reads zero", 12'h214, 32'h0);

    // R3 raw readback including bits 15 and 31
    bus_write(12'h200, 32'hFFFF_FFFF);
    bus_read("R3 raw word0", 12'h200, 32'hFFFF_FFFF);
    // R3 hold while bus_rd low
    @(negedge clk);
    check("R3 rdata hold", bus_rdata, 32'hFFFF_FFFF);

    // R4/R5: single-field words
    bus_write(12'h204, 32'h03E0_001F); // entry2 red, entry3 green
    bus_write(12'h208, 32'h8000_7C00); // entry4 blue, entry5 only bit15
    lookup(8'd2); // R5 red
    lookup(8'd3); // R4 upper half, R5 green
    lookup(8'd4); // R5 blue
    lookup(8'd5); // R6 intensity ignored -> 0
    @(negedge clk);
    check("R6 bit15 ignored", 32'(pix_rgb), 32'h0);
    check("R7 vld low when idle", 32'(pix_vld), 0);
    @(negedge clk);
    check("R7 rgb holds when idle", 32'(pix_rgb), 32'h0);
    bus_write(12'h20C, 32'h1234_5678);
    lookup(8'd6); lookup(8'd7); // R4 halves
    lookup(8'd0); lookup(8'd1); // R6 all-ones -> F8F8F8

    // R2 boundaries and outside window
    bus_write(12'h3FC, 32'hA5A5_5A5A);
    bus_read("R2 last word", 12'h3FC, 32'hA5A5_5A5A);
    lookup(8'd254); lookup(8'd255);
    bus_write(12'h400, 32'h1111_1111);
    bus_write(12'h1FC, 32'h2222_2222);
    bus_read("R2 word0 untouched by 0x400", 12'h200, 32'hFFFF_FFFF);
    bus_read("R2 word127 untouched by 0x1FC", 12'h3FC, 32'hA5A5_5A5A);
    bus_read("R2 outside read zero", 12'h400, 32'h0);
    bus_read("R2 outside read zero low", 12'h1FC, 32'h0);

    // R8 collision: write word3 while looking up entry 6
    pix_idx = 8'd6; pix_req = 1'b1;
    expq.push_back(color_of(8'd6));
    bus_addr = 12'h20C; bus_wdata = 32'h0000_7FFF; bus_wr = 1'b1;
    model[3] = 32'h0000_7FFF;
    @(negedge clk);
    pix_req = 1'b0; bus_wr = 1'b0;
    lookup(8'd6); // R8 new value next time

    // full sweep, back-to-back lookups
    for (int i = 0; i < 128; i++)
      bus_write(12'(12'h200 + 4 * i), {i[7:0] ^ 8'h5A, i[7:0], ~i[7:0], i[7:0] + 8'd3});
    for (int i = 0; i < 256; i++) lookup(8'(i));
    for (int i = 0; i < 128; i += 17)
      bus_read("R3 sweep readback", 12'(12'h200 + 4 * i), model[i]);

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", 32'(expq.size()), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule